// File: doc/BRIEF.md
# Four-Bit Stack-Operand ALU

This block is the arithmetic and logic unit of a zero-address processor core. Instructions name only an operation. The operands are implied by their place on a small on-chip expression stack. A binary operation combines the top entry (TOS) with the entry below it (NOS). The result replaces both, so the stack shrinks by one. A unary operation rewrites TOS in place. Two condition flags are updated: a carry/borrow flag and a branch flag.

The surrounding core presents one opcode per clock, qualified by a strobe. A push opcode loads a value from the push-data port. The block shows the current top entry, the number of stored entries, both flags, and a sticky error. The error is raised when the stack overflows or underflows. Results and flags are registered: an operation sampled at one rising edge is visible just after that edge.

Top module: `stack_alu4`

## Requirements
- R1: While reset is asserted and after it is released, the entry count is 0, TOS reads 0, and carry, branch and error are all 0.
- R2: PUSH (code 1) with fewer than 8 entries stores push_data as the new TOS and increments the count. Both flags keep their values.
- R3: Some operations are not legal on the current stack: PUSH with 8 entries, DROP or a unary operation with 0 entries, or a binary operation with fewer than 2 entries. Such an operation sets the error output and changes no other state. The error stays set until reset.
- R4: DROP (code 2) removes TOS and decrements the count. The flags are unchanged.
- R5: ADD (code 3) and ADDC (code 4) replace NOS and TOS with the 4-bit value NOS+TOS, or NOS+TOS+carry for ADDC, and decrement the count. Carry becomes the carry-out of bit 3. Branch is set when the result is zero.
- R6: SUB (code 5) replaces NOS and TOS with NOS-TOS modulo 16 and decrements the count. Carry becomes 1 exactly when NOS < TOS (a borrow). Branch is set when the result is zero.
- R7: AND (6), OR (7) and XOR (8) combine NOS and TOS bitwise into one result and decrement the count. Carry is cleared. Branch is set when the result is zero.
- R8: INC (9), DEC (10) and NOT (11) rewrite TOS and keep the count. INC sets carry when TOS was 15. DEC sets carry when TOS was 0. NOT clears carry. For all three, branch is set when the result is zero.
- R9: SHL (12) and SHR (13) shift TOS by one place and fill the vacated bit with 0. Carry and branch both take the bit shifted out: bit 3 for SHL, bit 0 for SHR.
- R10: ROL (14) and ROR (15) rotate the 5-bit value formed by carry and TOS. ROL moves carry into bit 0 and bit 3 into carry. ROR moves carry into bit 3 and bit 0 into carry. Branch equals the new carry.
- R11: NOP (code 0), or any cycle with the strobe low, changes no output.
- R12: Operations may be issued on back-to-back cycles. Each one is fully applied at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Strobe: the opcode is applied this cycle |
| op_code | input | 4 | Operation code |
| push_data | input | 4 | Value loaded by PUSH |
| tos | output | 4 | Current top-of-stack entry (0 when empty) |
| stk_count | output | 4 | Number of stored entries, 0 to 8 |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag |
| stk_err | output | 1 | Sticky overflow/underflow error |

## Verification
Every result of this block is due one rising edge after its strobe: the new TOS, the count, both flags and the error. Nothing takes longer, even for binary operations that reach below the top entry. The bench drives each operation just after a falling edge. It compares every output at the following falling edge against a bench model that has already applied the same operation. Entries below TOS are observed by later DROPs and binary operations, so a wrongly written lower slot shows up on TOS cycles afterwards.

// File: rtl/stack_alu4_pkg.sv
package stack_alu4_pkg;

    localparam int unsigned DATA_W = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_DROP = 4'd2,
        OP_ADD  = 4'd3,
        OP_ADDC = 4'd4,
        OP_SUB  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_NOT  = 4'd11,
        OP_SHL  = 4'd12,
        OP_SHR  = 4'd13,
        OP_ROL  = 4'd14,
        OP_ROR  = 4'd15
    } op_e;

    // Number of entries an opcode consumes from the stack.
    function automatic logic [1:0] op_arity(input op_e op);
        case (op)
            OP_NOP, OP_PUSH:                             return 2'd0;
            OP_ADD, OP_ADDC, OP_SUB,
            OP_AND, OP_OR, OP_XOR:                       return 2'd2;
            default:                                     return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/stack_file.sv
module stack_file #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (we && (waddr == AW'(g))) begin
                slot_d = wdata;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    assign rdata_a = slot_q[raddr_a];
    assign rdata_b = slot_q[raddr_b];

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import stack_alu4_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] top,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         bflag
);

    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    logic [W:0] wide;
    logic       zero_res;

    always_comb begin
        wide  = '0;
        res   = top;
        cout  = cin;
        bflag = 1'b0;
        case (op)
            OP_ADD, OP_ADDC: begin
                wide = {1'b0, nos} + {1'b0, top} + ((op == OP_ADDC && cin) ? ONE : '0);
                res  = wide[W-1:0];
                cout = wide[W];
            end
            OP_SUB: begin
                wide = {1'b0, nos} - {1'b0, top};
                res  = wide[W-1:0];
                cout = wide[W];
            end
            OP_AND: begin res = nos & top; cout = 1'b0; end
            OP_OR:  begin res = nos | top; cout = 1'b0; end
            OP_XOR: begin res = nos ^ top; cout = 1'b0; end
            OP_INC: begin
                wide = {1'b0, top} + ONE;
                res  = wide[W-1:0];
                cout = wide[W];
            end
            OP_DEC: begin
                wide = {1'b0, top} - ONE;
                res  = wide[W-1:0];
                cout = wide[W];
            end
            OP_NOT: begin res = ~top; cout = 1'b0; end
            OP_SHL: begin res = {top[W-2:0], 1'b0}; cout = top[W-1]; end
            OP_SHR: begin res = {1'b0, top[W-1:1]}; cout = top[0]; end
            OP_ROL: begin res = {top[W-2:0], cin}; cout = top[W-1]; end
            OP_ROR: begin res = {cin, top[W-1:1]}; cout = top[0]; end
            default: begin res = top; cout = cin; end
        endcase
        zero_res = (res == '0);
        case (op)
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: bflag = cout;
            default:                        bflag = zero_res;
        endcase
    end

endmodule

// File: rtl/stack_alu4.sv
module stack_alu4
    import stack_alu4_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned W    = DATA_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [W-1:0]  push_data,
    output logic [W-1:0]  tos,
    output logic [CW-1:0] stk_count,
    output logic          carry,
    output logic          branch,
    output logic          stk_err
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] C1   = CW'(1);
    localparam logic [CW-1:0] C2   = CW'(2);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          carry;
        logic          branch;
        logic          err;
    } state_t;

    state_t st_d, st_q;

    op_e           op;
    logic [CW-1:0] idx_top, idx_nos;
    logic [W-1:0]  rd_top, rd_nos;
    logic [W-1:0]  alu_res;
    logic          alu_cout, alu_bflag;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_data;

    assign op      = op_e'(op_code);
    assign idx_top = st_q.count - C1;
    assign idx_nos = st_q.count - C2;

    stack_file #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (idx_top[AW-1:0]),
        .raddr_b (idx_nos[AW-1:0]),
        .rdata_a (rd_top),
        .rdata_b (rd_nos)
    );

    alu4_core #(.W(W)) u_alu (
        .op    (op),
        .nos   (rd_nos),
        .top   (rd_top),
        .cin   (st_q.carry),
        .res   (alu_res),
        .cout  (alu_cout),
        .bflag (alu_bflag)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        if (op_valid && op != OP_NOP) begin
            if (op == OP_PUSH) begin
                if (st_q.count == FULL) begin
                    st_d.err = 1'b1;
                end else begin
                    wr_en      = 1'b1;
                    wr_addr    = st_q.count[AW-1:0];
                    wr_data    = push_data;
                    st_d.count = st_q.count + C1;
                end
            end else if (st_q.count < CW'(op_arity(op))) begin
                st_d.err = 1'b1;
            end else if (op == OP_DROP) begin
                st_d.count = idx_top;
            end else if (op_arity(op) == 2'd2) begin
                wr_en       = 1'b1;
                wr_addr     = idx_nos[AW-1:0];
                wr_data     = alu_res;
                st_d.count  = idx_top;
                st_d.carry  = alu_cout;
                st_d.branch = alu_bflag;
            end else begin
                wr_en       = 1'b1;
                wr_addr     = idx_top[AW-1:0];
                wr_data     = alu_res;
                st_d.carry  = alu_cout;
                st_d.branch = alu_bflag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos       = (st_q.count == '0) ? '0 : rd_top;
    assign stk_count = st_q.count;
    assign carry     = st_q.carry;
    assign branch    = st_q.branch;
    assign stk_err   = st_q.err;

endmodule

// File: rtl/stack_alu4_chk.sv
module stack_alu4_chk
    import stack_alu4_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic [3:0] push_data,
    input logic [3:0] tos,
    input logic [3:0] stk_count,
    input logic       carry,
    input logic       branch,
    input logic       stk_err
);

    logic is_push, is_bin, is_una;
    assign is_push = op_valid && op_code == OP_PUSH;
    assign is_bin  = op_valid && op_code >= OP_ADD && op_code <= OP_XOR;
    assign is_una  = op_valid && op_code >= OP_INC;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (stk_count == 4'd0 && !stk_err && !carry && !branch));

    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && stk_count < 4'd8) |=>
            (tos == $past(push_data) && stk_count == $past(stk_count) + 4'd1));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= 4'd8);

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && stk_count == 4'd8) |=> (stk_err && $stable(stk_count) && $stable(tos)));

    p_binary_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bin && stk_count >= 4'd2) |=> stk_count == $past(stk_count) - 4'd1);

    p_unary_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_una && stk_count >= 4'd1) |=> $stable(stk_count));

    p_rotl_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ROL && stk_count != 4'd0) |=>
            (carry == $past(tos[3]) && tos[0] == $past(carry) && branch == carry));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(tos) && $stable(stk_count) && $stable(carry)
                       && $stable(branch) && $stable(stk_err)));

endmodule

bind stack_alu4 stack_alu4_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .push_data (push_data),
    .tos       (tos),
    .stk_count (stk_count),
    .carry     (carry),
    .branch    (branch),
    .stk_err   (stk_err)
);

// File: tb/stack_alu4_bench.sv
`timescale 1ns/1ps
module stack_alu4_bench;

    localparam real TCK = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [3:0] push_data = 4'd0;
    logic [3:0] tos;
    logic [3:0] stk_count;
    logic       carry, branch, stk_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int m_stk [8];
    int m_cnt;
    bit m_c, m_b, m_e;

    always #(TCK / 2) clk = ~clk;

    stack_alu4 u_stack_alu4 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .push_data(push_data), .tos(tos), .stk_count(stk_count),
        .carry(carry), .branch(branch), .stk_err(stk_err)
    );

    function automatic string req_of(input int op);
        case (op)
            0: return "R11";
            1: return "R2";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7, 8: return "R7";
            9, 10, 11: return "R8";
            12, 13: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int arity(input int op);
        if (op <= 1) return 0;
        if (op >= 3 && op <= 8) return 2;
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
        m_cnt = 0; m_c = 0; m_b = 0; m_e = 0;
    endtask

    task automatic model_apply(input bit v, input int op, input int d);
        int a, b, r, c;
        if (!v || op == 0) return;
        if (op == 1) begin
            if (m_cnt == 8) m_e = 1;
            else begin m_stk[m_cnt] = d; m_cnt++; end
            return;
        end
        if (m_cnt < arity(op)) begin m_e = 1; return; end
        if (op == 2) begin m_cnt--; return; end
        b = m_stk[m_cnt-1];
        a = (m_cnt >= 2) ? m_stk[m_cnt-2] : 0;
        c = m_c;
        case (op)
            3: begin r = a + b; c = r > 15; end
            4: begin r = a + b + m_c; c = r > 15; end
            5: begin r = a - b; c = a < b; end
            6: begin r = a & b; c = 0; end
            7: begin r = a | b; c = 0; end
            8: begin r = a ^ b; c = 0; end
            9: begin r = b + 1; c = b == 15; end
            10: begin r = b - 1; c = b == 0; end
            11: begin r = ~b; c = 0; end
            12: begin r = b << 1; c = (b >> 3) & 1; end
            13: begin r = b >> 1; c = b & 1; end
            14: begin r = (b << 1) | m_c; c = (b >> 3) & 1; end
            default: begin r = (b >> 1) | (m_c << 3); c = b & 1; end
        endcase
        r = r & 15;
        m_c = c[0];
        m_b = (op >= 12) ? c[0] : (r == 0);
        if (arity(op) == 2) begin m_stk[m_cnt-2] = r; m_cnt--; end
        else m_stk[m_cnt-1] = r;
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "tos", tos, (m_cnt == 0) ? 0 : m_stk[m_cnt-1]);
        chk(req, "count", stk_count, m_cnt);
        chk(req, "carry", carry, m_c);
        chk(req, "branch", branch, m_b);
        chk(req, "err", stk_err, m_e);
    endtask

    // Drive right after a falling edge; outputs settle at the next falling edge (R12).
    task automatic step(input bit v, input int op, input int d);
        op_valid  = v;
        op_code   = 4'(op);
        push_data = 4'(d);
        model_apply(v, op, d);
        @(negedge clk);
        chk_all(v ? req_of(op) : "R11");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_valid = 1'b0;
        model_reset();
        @(negedge clk);
        chk_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R2 / R5: add with carry-out and zero result
        step(1, 1, 7); step(1, 1, 9); step(1, 3, 0);
        // R5: add with carry in
        step(1, 1, 15); step(1, 4, 0);
        // R6: borrow case and no-borrow equal case
        step(1, 1, 2); step(1, 1, 5); step(1, 5, 0);
        step(1, 1, 13); step(1, 5, 0);
        // R7 logical
        step(1, 1, 12); step(1, 1, 10); step(1, 6, 0);
        step(1, 1, 5); step(1, 7, 0); step(1, 1, 13); step(1, 8, 0);
        // R8 unary at the edges
        step(1, 1, 15); step(1, 9, 0); step(1, 10, 0); step(1, 11, 0);
        // R9 / R10 shifts and rotates through carry
        step(1, 1, 9); step(1, 12, 0); step(1, 13, 0);
        step(1, 14, 0); step(1, 14, 0); step(1, 15, 0); step(1, 15, 0);
        // R11: idle and NOP
        step(0, 3, 0); step(1, 0, 6);
        // R4 drain, then R3 underflow leaves state alone
        while (m_cnt > 0) step(1, 2, 0);
        step(1, 2, 0);
        step(1, 3, 0);
        step(1, 1, 4); step(1, 5, 0);
        // R3 overflow at full depth
        while (m_cnt < 8) step(1, 1, m_cnt + 1);
        step(1, 1, 3);
        step(1, 9, 0);
        do_reset();
        // random mix, back to back (R12)
        for (int i = 0; i < 4000; i++) begin
            int op;
            bit v;
            v  = ($urandom_range(0, 9) != 0);
            op = $urandom_range(0, 15);
            if (m_cnt < 2 && $urandom_range(0, 3) != 0) op = 1;
            if (m_cnt > 6 && op == 1 && $urandom_range(0, 3) != 0) op = 3;
            step(v, op, $urandom_range(0, 15));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule